// File: doc/BRIEF.md
# Log-Quantized Shift-Accumulate Element

This block is one processing element of a narrow-data convolution array. Weights reach it as a quantized base-2 logarithm, so every weight is plus or minus a power of two. Multiplying by such a weight is a shift, and the element therefore contains a barrel shifter in each lane and no multiplier. Activations are small unsigned magnitudes. One input beat packs `LANES` operands of `CODE_W` bits into each of two words, one for weight codes and one for activations. With the defaults this is four 4-bit operands in each 16-bit word, which gives four products per word fetched.

Each lane produces a signed term. The lane terms are summed into one beat total, and that total goes into a signed accumulator that saturates instead of wrapping. A `clr` pulse starts a new dot product. A beat marked `in_last` closes the dot product, and the result is presented one cycle later with a strobe. The same rules apply at 5-bit code width by setting `CODE_W`.

Top module: `lq_shift_mac`

## Requirements
- R1: Reset state. While `rst_n` is low and after it is released, `res_valid` is 0 and `res_data` is 0.
- R2: Lane term rule. In a weight code of width W, bit W-1 is the sign (1 = negative) and bits W-2..0 form the exponent e. Let F = 2^(W-1) - 2. The lane term is the activation times 2^(F-e), negated when the sign bit is 1. This is exact and keeps no fraction bits.
- R3: An exponent field of all ones (e = 2^(W-1) - 1) contributes zero, whatever the sign bit and the activation are.
- R4: Lane packing. Lane k sits in bits [k*W +: W] of both `w_word` and `a_word`. The terms of all lanes are summed, lowest lane first, and the sum is added to the accumulator as one update per valid beat.
- R5: When `clr` is high and `in_valid` is low, the accumulator becomes 0 at the next clock edge, and `res_data` then reads 0.
- R6: When `clr` and `in_valid` are high in the same cycle, the beat is accumulated onto zero, so the new dot product starts with that beat.
- R7: `res_valid` is high for exactly the one cycle after a beat that has both `in_valid` and `in_last` high, and low in every other cycle. In that cycle `res_data` holds the total including the last beat.
- R8: The accumulator saturates. If an update would exceed 2^(ACC_W-1) - 1 it holds that value, and if an update would go below -2^(ACC_W-1) it holds that value. Later updates continue from the clamped value.
- R9: With `CODE_W` = 5 (20-bit words), rules R2 to R4 hold unchanged, with F = 14 and an all-ones exponent of 15.
- R10: While `in_valid` is low, `in_last`, `w_word` and `a_word` have no effect. `res_valid` stays low and `res_data` is unchanged, unless `clr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Start a new dot product (zero the accumulator) |
| in_valid | input | 1 | Input beat present |
| in_last | input | 1 | Beat closes the dot product |
| w_word | input | LANES*CODE_W | Packed log weight codes, lane 0 lowest |
| a_word | input | LANES*CODE_W | Packed unsigned activations, lane 0 lowest |
| res_valid | output | 1 | Result strobe, one cycle after the last beat |
| res_data | output | ACC_W | Signed accumulator value |

## Verification
The lane shifters and the lane sum are combinational, and the accumulator is the only register on the data path. A beat's contribution is therefore visible in `res_data` in the cycle after the beat, and `res_valid` goes high in that same cycle when the beat carried `in_last`. The bench applies each beat half a period before the capturing edge. It compares `res_data` and `res_valid` at the falling edge that follows that capture, and for idle or non-final beats it checks at that same edge that the strobe stays low. Expected totals come from a power-of-two multiplication and a per-beat clamp written independently in the bench. The bench sweeps every weight and activation code of the 4-bit and 5-bit configurations, and a narrow-accumulator instance exercises both saturation limits.

// File: rtl/lq_pkg.sv
package lq_pkg;

  // Signed lane term for a log-coded weight and an unsigned activation.
  function automatic longint lq_term(input int cw, input logic [31:0] wcode,
                                     input logic [31:0] act);
    int     emax;
    int     frac;
    int     e;
    logic   neg;
    longint mag;
    emax = (1 << (cw - 1)) - 1;
    frac = emax - 1;
    e    = int'(wcode) & emax;
    neg  = wcode[cw-1];
    if (e == emax) return 64'sd0;
    mag = longint'({32'd0, act}) << (frac - e);
    return neg ? -mag : mag;
  endfunction

  function automatic longint lq_acc_max(input int w);
    return (longint'(1) <<< (w - 1)) - 1;
  endfunction

  function automatic longint lq_acc_min(input int w);
    return -lq_acc_max(w) - 1;
  endfunction

endpackage

// File: rtl/lq_lane_shift.sv
module lq_lane_shift #(
  parameter int CODE_W  = 4,
  parameter int TERM_SW = 12
) (
  input  logic [CODE_W-1:0]         wcode,
  input  logic [CODE_W-1:0]         act,
  output logic signed [TERM_SW-1:0] term
);
  import lq_pkg::*;

  always_comb begin
    term = TERM_SW'(lq_term(CODE_W, 32'(wcode), 32'(act)));
  end
endmodule

// File: rtl/lq_lane_sum.sv
module lq_lane_sum #(
  parameter int LANES   = 4,
  parameter int TERM_SW = 12,
  parameter int SUM_W   = 14
) (
  input  logic [LANES*TERM_SW-1:0] terms,
  output logic signed [SUM_W-1:0]  sum
);
  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++) begin
      sum = sum + SUM_W'(signed'(terms[i*TERM_SW +: TERM_SW]));
    end
  end
endmodule

// File: rtl/lq_sat_acc.sv
module lq_sat_acc #(
  parameter int ACC_W = 24,
  parameter int SUM_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    add_en,
  input  logic signed [SUM_W-1:0] addend,
  output logic signed [ACC_W-1:0] acc_q,
  output logic                    sat_hi,
  output logic                    sat_lo
);
  import lq_pkg::*;

  longint base_l;
  longint raw_l;
  longint nxt_l;

  always_comb begin
    base_l = clr ? 64'sd0 : longint'(acc_q);
    raw_l  = base_l + longint'(addend);
    sat_hi = add_en && (raw_l > lq_acc_max(ACC_W));
    sat_lo = add_en && (raw_l < lq_acc_min(ACC_W));
    if (raw_l > lq_acc_max(ACC_W))      nxt_l = lq_acc_max(ACC_W);
    else if (raw_l < lq_acc_min(ACC_W)) nxt_l = lq_acc_min(ACC_W);
    else                                nxt_l = raw_l;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (add_en) acc_q <= ACC_W'(nxt_l);
    else if (clr)    acc_q <= '0;
  end
endmodule

// File: rtl/lq_shift_mac.sv
module lq_shift_mac #(
  parameter int CODE_W = 4,
  parameter int LANES  = 4,
  parameter int ACC_W  = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      in_valid,
  input  logic                      in_last,
  input  logic [LANES*CODE_W-1:0]   w_word,
  input  logic [LANES*CODE_W-1:0]   a_word,
  output logic                      res_valid,
  output logic signed [ACC_W-1:0]   res_data
);
  localparam int FRAC_W  = (1 << (CODE_W - 1)) - 2;
  localparam int TERM_SW = CODE_W + FRAC_W + 1;
  localparam int SUM_W   = TERM_SW + $clog2(LANES) + 1;

  logic [LANES*TERM_SW-1:0] lane_terms;
  logic signed [SUM_W-1:0]  beat_sum;
  logic                     sat_hi_evt;
  logic                     sat_lo_evt;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lq_lane_shift #(.CODE_W(CODE_W), .TERM_SW(TERM_SW)) u_shift (
      .wcode (w_word[k*CODE_W +: CODE_W]),
      .act   (a_word[k*CODE_W +: CODE_W]),
      .term  (lane_terms[k*TERM_SW +: TERM_SW])
    );
  end

  lq_lane_sum #(.LANES(LANES), .TERM_SW(TERM_SW), .SUM_W(SUM_W)) u_sum (
    .terms (lane_terms),
    .sum   (beat_sum)
  );

  lq_sat_acc #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .add_en (in_valid),
    .addend (beat_sum),
    .acc_q  (res_data),
    .sat_hi (sat_hi_evt),
    .sat_lo (sat_lo_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= in_valid && in_last;
  end
endmodule

// File: rtl/lq_shift_mac_chk.sv
module lq_shift_mac_chk #(
  parameter int ACC_W = 24,
  parameter int SUM_W = 14
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    in_valid,
  input logic                    in_last,
  input logic                    res_valid,
  input logic signed [ACC_W-1:0] res_data,
  input logic signed [SUM_W-1:0] beat_sum,
  input logic                    sat_hi_evt,
  input logic                    sat_lo_evt
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> res_valid);                              // R7
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !res_valid);                            // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !in_valid) |=> (res_data == '0));                          // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !in_valid) |=> $stable(res_data));                        // R10
  AST_ZERO_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr && beat_sum == '0) |=> $stable(res_data));       // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hi_evt |=> (res_data == ACC_MAX));                             // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sat_lo_evt |=> (res_data == ACC_MIN));                             // R8
endmodule

bind lq_shift_mac lq_shift_mac_chk #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_lq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .in_valid   (in_valid),
  .in_last    (in_last),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .beat_sum   (beat_sum),
  .sat_hi_evt (sat_hi_evt),
  .sat_lo_evt (sat_lo_evt)
);

// File: tb/lq_shift_mac_bench.sv
`timescale 1ns/1ps
module lq_shift_mac_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic [15:0] w4 = '0, a4 = '0;
  logic [19:0] w5 = '0, a5 = '0;
  logic rv_a, rv_b, rv_c;
  logic signed [23:0] rd_a;
  logic signed [11:0] rd_b;
  logic signed [23:0] rd_c;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lq_shift_mac u_lq_shift_mac (.clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_last(in_last), .w_word(w4), .a_word(a4), .res_valid(rv_a), .res_data(rd_a));
  lq_shift_mac #(.ACC_W(12)) u_lq_narrow (.clk(clk), .rst_n(rst_n), .clr(clr),
    .in_valid(in_valid), .in_last(in_last), .w_word(w4), .a_word(a4),
    .res_valid(rv_b), .res_data(rd_b));
  lq_shift_mac #(.CODE_W(5)) u_lq_wide (.clk(clk), .rst_n(rst_n), .clr(clr),
    .in_valid(in_valid), .in_last(in_last), .w_word(w5), .a_word(a5),
    .res_valid(rv_c), .res_data(rd_c));

  // Expected term: activation times a power of two, written as a multiply.
  function automatic longint exp_term(input int cw, input int w, input int a);
    int h = 1 << (cw - 1);
    int e = w % h;
    longint mag;
    if (e == h - 1) return 0;
    mag = longint'(a) * (longint'(2) ** (h - 2 - e));
    return (w / h) != 0 ? -mag : mag;
  endfunction

  function automatic longint clampv(input longint v, input int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic beat(input bit last, input bit with_clr);
    in_valid = 1'b1; in_last = last; clr = with_clr;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; clr = 1'b0;
  endtask

  task automatic clear_only();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    longint ea, eb, ec, sum4;
    int seed;
    repeat (3) @(negedge clk);
    chk("R1 valid during reset", longint'(rv_a), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", longint'(rv_a), 0);
    chk("R1 data after reset", longint'(rd_a), 0);
    chk("R1 data narrow", longint'(rd_b), 0);
    chk("R1 data wide", longint'(rd_c), 0);

    // R2 R4 R6 R8: every 4-bit weight/activation pair, clear with the beat
    for (int w = 0; w < 16; w++) begin
      for (int a = 0; a < 16; a++) begin
        int k = (w + a) % 4;
        sum4 = 0;
        for (int j = 0; j < 4; j++) begin
          int wj = (j == k) ? w : (j * 5 + w) % 16;
          int aj = (j == k) ? a : (a + j * 3) % 16;
          w4[j*4 +: 4] = 4'(wj);
          a4[j*4 +: 4] = 4'(aj);
          sum4 += exp_term(4, wj, aj);
        end
        beat(1'b1, 1'b1);
        chk("R2 R4 R6 sweep result", longint'(rd_a), sum4);
        chk("R7 strobe on last", longint'(rv_a), 1);
        chk("R8 narrow clamp", longint'(rd_b), clampv(sum4, 12));
      end
    end

    // R9: every 5-bit pair on the wide instance
    w4 = '0; a4 = '0;
    for (int w = 0; w < 32; w++) begin
      for (int a = 0; a < 32; a++) begin
        int k = (w * 3 + a) % 4;
        sum4 = 0;
        for (int j = 0; j < 4; j++) begin
          int wj = (j == k) ? w : (j * 7 + w) % 32;
          int aj = (j == k) ? a : (a + j * 5) % 32;
          w5[j*5 +: 5] = 5'(wj);
          a5[j*5 +: 5] = 5'(aj);
          sum4 += exp_term(5, wj, aj);
        end
        beat(1'b1, 1'b1);
        chk("R9 5-bit sweep result", longint'(rd_c), sum4);
      end
    end

    // R3: every lane carries an all-ones exponent, either sign
    clear_only();
    chk("R5 clear alone", longint'(rd_a), 0);
    w4 = 16'hF7F7; a4 = 16'hFFFF; w5 = 20'h7BDEF; a5 = 20'hFFFFF;
    beat(1'b1, 1'b0);
    chk("R3 zero code 4-bit", longint'(rd_a), 0);
    chk("R3 zero code 5-bit", longint'(rd_c), 0);

    // R7 R5: multi-beat dot products
    seed = 12345;
    for (int d = 0; d < 24; d++) begin
      int len = 1 + d % 8;
      clear_only();
      chk("R5 clear before product", longint'(rd_a), 0);
      ea = 0; eb = 0; ec = 0;
      for (int b = 0; b < len; b++) begin
        sum4 = 0;
        for (int j = 0; j < 4; j++) begin
          int wj, aj;
          seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
          wj = (seed >> 8) % 16;
          aj = (seed >> 16) % 16;
          w4[j*4 +: 4] = 4'(wj);
          a4[j*4 +: 4] = 4'(aj);
          sum4 += exp_term(4, wj, aj);
        end
        ea = clampv(ea + sum4, 24);
        eb = clampv(eb + sum4, 12);
        beat(b == len - 1, 1'b0);
        if (b != len - 1) chk("R7 no strobe mid product", longint'(rv_a), 0);
      end
      chk("R7 strobe after last", longint'(rv_a), 1);
      chk("R7 product total", longint'(rd_a), ea);
      chk("R8 narrow product total", longint'(rd_b), eb);
      w4 = 16'h1234; a4 = 16'hFFFF; in_last = 1'b1;
      @(negedge clk);
      in_last = 1'b0;
      chk("R10 idle strobe low", longint'(rv_a), 0);
      chk("R10 idle data held", longint'(rd_a), ea);
    end

    // R8: drive the narrow accumulator into both limits
    clear_only();
    w4 = 16'h0000; a4 = 16'hFFFF;
    for (int b = 0; b < 3; b++) beat(1'b0, 1'b0);
    chk("R8 high limit", longint'(rd_b), 2047);
    chk("R8 wide keeps exact", longint'(rd_a), 3 * 3840);
    w4 = 16'h7778; a4 = 16'h0001;
    beat(1'b0, 1'b0);
    chk("R8 leave high limit", longint'(rd_b), 2047 - 64);
    w4 = 16'h8888; a4 = 16'hFFFF;
    for (int b = 0; b < 4; b++) beat(1'b0, 1'b0);
    chk("R8 low limit", longint'(rd_b), -2048);
    beat(1'b1, 1'b0);
    chk("R8 low limit held", longint'(rd_b), -2048);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule